// File: doc/BRIEF.md
# Buffered Edge-Aligned PWM Channel

A single PWM channel whose waveform is aligned to the start of each period. An up-counter advances once per tick, a strobe that a separate prescaler raises for one system clock. The channel compares the counter against an active period value and an active duty value. The counter runs from 0 to one less than the period, then wraps. A duty match moves the output from its starting level to its second level. At the wrap the output goes back to the starting level.

Software reaches the channel through a small write port. One select value writes the period, one writes the duty, and one writes a control field that holds an enable bit and a polarity bit. While the channel runs, period and duty writes land in buffer registers. The buffers are copied into the active compare registers only at the period wrap, so the output never sees a half-updated period. While the channel is stopped, writes go straight through to the active registers. The counter then rests at 0 and the output holds its starting level. The polarity bit sets that starting level.

Top module: `pwm_edge_channel`

## Requirements
- R1: After reset the channel is disabled, the polarity bit is 0 and `pwmOut` is 0.
- R2: While enabled with a nonzero active period P, the counter advances by one only on clock edges where `tick` is 1, runs through 0..P-1 and wraps to 0. The output repeats every P ticks.
- R3: While disabled, the counter is 0 and `pwmOut` equals the polarity bit. A period or duty write takes effect in the active registers at once.
- R4: While enabled with nonzero period, `pwmOut` is the polarity bit XOR (counter >= active duty). With polarity 0 the output is low before the duty match and high from it. With polarity 1 it is the inverse.
- R5: While enabled, period and duty writes only fill the buffers. The buffers are copied into the active registers on the tick edge where the counter wraps from P-1 to 0. Until then the active values stay unchanged.
- R6: An active duty of 0 gives the second level for the whole period. An active duty >= the active period gives the starting level for the whole period.
- R7: While enabled with an active period of 0, the counter stays at 0 and `pwmOut` equals the polarity bit.
- R8: Writes are decoded from `wrSel`: 0 = period, 1 = duty, 2 = control (`wrData[0]` enable, `wrData[1]` polarity). A write with select 3 has no effect. Every write, and every change of state, appears on `pwmOut` after exactly one clock edge.
- R9: With a tick on every clock, polarity 0, period 4 and duty 1, the output repeats every 4 clocks and is high for 3 of them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Write target: 0 period, 1 duty, 2 control, 3 none |
| wrData | input | CNT_W | Write data |
| tick | input | 1 | Count enable from the prescaler |
| pwmOut | output | 1 | Registered PWM output |

## Verification
The bench builds the channel with a 4-bit counter (`CNT_W = 4`). This keeps the largest period, 15, short enough to run several complete cycles at the top of the range, which checks that the counter wraps at 14 and never overflows. Under the same setting, duty values beyond the period and a duty match on the very last count are each reached within a few dozen clocks. Buffered updates are tested by writing new values mid-period and confirming that the old period runs to its end before the new one starts.

// File: rtl/pwm_edge_pkg.sv
package pwm_edge_pkg;

  localparam logic [1:0] SEL_PER = 2'd0;
  localparam logic [1:0] SEL_DUT = 2'd1;
  localparam logic [1:0] SEL_CTL = 2'd2;

  // strobes from control to datapath, all valid for the current clock
  typedef struct packed {
    logic wrPer;    // period write this cycle
    logic wrDut;    // duty write this cycle
    logic direct;   // channel stopped: writes reach active registers
    logic adv;      // running and tick present
    logic nextEn;   // enable after this edge
    logic nextPol;  // polarity after this edge
  } pwmStrb_t;

endpackage

// File: rtl/pwm_edge_ctrl.sv
module pwm_edge_ctrl
  import pwm_edge_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [1:0] wrSel,
  input  logic [1:0] ctlBits,
  input  logic       tick,
  output pwmStrb_t   strb,
  output logic       enQ,
  output logic       polQ
);

  logic wrCtl;

  always_comb begin
    wrCtl        = wrEn && (wrSel == SEL_CTL);
    strb.wrPer   = wrEn && (wrSel == SEL_PER);
    strb.wrDut   = wrEn && (wrSel == SEL_DUT);
    strb.direct  = !enQ;
    strb.adv     = enQ && tick;
    strb.nextEn  = wrCtl ? ctlBits[0] : enQ;
    strb.nextPol = wrCtl ? ctlBits[1] : polQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ  <= 1'b0;
      polQ <= 1'b0;
    end else begin
      enQ  <= strb.nextEn;
      polQ <= strb.nextPol;
    end
  end

endmodule

// File: rtl/pwm_edge_dpath.sv
module pwm_edge_dpath
  import pwm_edge_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  pwmStrb_t         strb,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] cntQ,
  output logic [CNT_W-1:0] actPerQ,
  output logic [CNT_W-1:0] actDutQ,
  output logic             pwmQ
);

  localparam int NREG = 2;  // slot 0 period, slot 1 duty

  logic [CNT_W-1:0] bufQ  [NREG];
  logic [CNT_W-1:0] actQ  [NREG];
  logic [CNT_W-1:0] actNext [NREG];
  logic [NREG-1:0]  wrSlot;
  logic [CNT_W-1:0] lastCnt;
  logic [CNT_W-1:0] cntNext;
  logic             atEnd;
  logic             phaseNext;

  assign wrSlot  = {strb.wrDut, strb.wrPer};
  assign lastCnt = actQ[0] - CNT_W'(1);
  assign atEnd   = strb.adv && (actQ[0] != '0) && (cntQ == lastCnt);

  for (genvar i = 0; i < NREG; i++) begin : g_slot
    always_comb begin
      actNext[i] = actQ[i];
      if (atEnd)
        actNext[i] = bufQ[i];
      else if (strb.direct && wrSlot[i])
        actNext[i] = wrData;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        bufQ[i] <= '0;
        actQ[i] <= '0;
      end else begin
        if (wrSlot[i]) bufQ[i] <= wrData;
        actQ[i] <= actNext[i];
      end
    end
  end

  always_comb begin
    cntNext = cntQ;
    if (strb.adv && (actQ[0] != '0))
      cntNext = atEnd ? '0 : cntQ + CNT_W'(1);
    if (!strb.nextEn)
      cntNext = '0;
    phaseNext = strb.nextEn && (actNext[0] != '0) && (cntNext >= actNext[1]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
      pwmQ <= 1'b0;
    end else begin
      cntQ <= cntNext;
      pwmQ <= strb.nextPol ^ phaseNext;
    end
  end

  assign actPerQ = actQ[0];
  assign actDutQ = actQ[1];

endmodule

// File: rtl/pwm_edge_channel.sv
module pwm_edge_channel
  import pwm_edge_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrSel,
  input  logic [CNT_W-1:0] wrData,
  input  logic             tick,
  output logic             pwmOut
);

  pwmStrb_t         strb;
  logic             enQ;
  logic             polQ;
  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] actPerQ;
  logic [CNT_W-1:0] actDutQ;

  pwm_edge_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrSel   (wrSel),
    .ctlBits (wrData[1:0]),
    .tick    (tick),
    .strb    (strb),
    .enQ     (enQ),
    .polQ    (polQ)
  );

  pwm_edge_dpath #(.CNT_W(CNT_W)) dpath_i (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wrData  (wrData),
    .cntQ    (cntQ),
    .actPerQ (actPerQ),
    .actDutQ (actDutQ),
    .pwmQ    (pwmOut)
  );

endmodule

// File: rtl/pwm_edge_chk.sv
module pwm_edge_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [1:0]       wrSel,
  input logic             tick,
  input logic             pwmOut,
  input logic             enQ,
  input logic             polQ,
  input logic [CNT_W-1:0] cntQ,
  input logic [CNT_W-1:0] actPerQ,
  input logic [CNT_W-1:0] actDutQ
);

  logic ctlWr;
  logic wrapNow;
  assign ctlWr   = wrEn && (wrSel == 2'd2);
  assign wrapNow = tick && (actPerQ != '0) && (cntQ == actPerQ - CNT_W'(1));

  p_idle_level_r3: assert property (@(posedge clk) disable iff (!rstN)
    !enQ |-> (cntQ == '0) && (pwmOut == polQ));

  p_count_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    (enQ && actPerQ != '0) |-> (cntQ < actPerQ));

  p_hold_no_tick_r2: assert property (@(posedge clk) disable iff (!rstN)
    (enQ && !tick && !ctlWr) |=> $stable(cntQ));

  p_level_rule_r4: assert property (@(posedge clk) disable iff (!rstN)
    (enQ && actPerQ != '0) |-> (pwmOut == (polQ ^ (cntQ >= actDutQ))));

  p_zero_period_r7: assert property (@(posedge clk) disable iff (!rstN)
    (enQ && actPerQ == '0) |-> (cntQ == '0) && (pwmOut == polQ));

  p_buffer_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (enQ && !wrapNow) |=> $stable(actPerQ) && $stable(actDutQ));

endmodule

bind pwm_edge_channel pwm_edge_chk #(.CNT_W(CNT_W)) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .wrEn    (wrEn),
  .wrSel   (wrSel),
  .tick    (tick),
  .pwmOut  (pwmOut),
  .enQ     (enQ),
  .polQ    (polQ),
  .cntQ    (cntQ),
  .actPerQ (actPerQ),
  .actDutQ (actDutQ)
);

// File: tb/pwm_edge_channel_tb_top.sv
module pwm_edge_channel_tb_top;

  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         wrEn = 1'b0;
  logic [1:0]   wrSel = 2'd0;
  logic [W-1:0] wrData = '0;
  logic         tick = 1'b0;
  logic         pwmOut;

  int checks = 0;
  int errors = 0;
  bit driverDone = 1'b0;

  typedef struct {
    logic  val;
    string req;
  } expItem_t;

  expItem_t expQ[$];

  // reference state, built from the requirements
  logic         mEn = 1'b0, mPol = 1'b0;
  logic [W-1:0] mCnt = '0, mAP = '0, mAD = '0, mBP = '0, mBD = '0;

  always #4 clk = ~clk;  // 125 MHz

  pwm_edge_channel #(.CNT_W(W)) dut_i (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrSel  (wrSel),
    .wrData (wrData),
    .tick   (tick),
    .pwmOut (pwmOut)
  );

  task automatic check(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s pwmOut actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // driver: applies one cycle of stimulus and queues the expected output
  task automatic step(input logic w, input logic [1:0] s, input logic [W-1:0] d,
                      input logic t, input string req);
    logic         nEn, nPol;
    logic [W-1:0] nCnt, nAP, nAD, nBP, nBD;
    expItem_t     it;
    @(negedge clk);
    wrEn = w; wrSel = s; wrData = d; tick = t;
    nEn  = (w && s == 2'd2) ? d[0] : mEn;
    nPol = (w && s == 2'd2) ? d[1] : mPol;
    nCnt = mCnt; nAP = mAP; nAD = mAD; nBP = mBP; nBD = mBD;
    if (w && s == 2'd0) begin nBP = d; if (!mEn) nAP = d; end
    if (w && s == 2'd1) begin nBD = d; if (!mEn) nAD = d; end
    if (mEn && t && mAP != '0) begin
      if (mCnt == W'(mAP - W'(1))) begin
        nCnt = '0; nAP = mBP; nAD = mBD;
      end else nCnt = mCnt + W'(1);
    end
    if (!nEn) nCnt = '0;
    mEn = nEn; mPol = nPol; mCnt = nCnt; mAP = nAP; mAD = nAD; mBP = nBP; mBD = nBD;
    it.val = mPol ^ (mEn && mAP != '0 && mCnt >= mAD);
    it.req = req;
    expQ.push_back(it);
  endtask

  task automatic run(input int n, input logic t, input string req);
    for (int i = 0; i < n; i++) step(1'b0, 2'd0, '0, t, req);
  endtask

  task automatic wr(input logic [1:0] s, input logic [W-1:0] d, input string req);
    step(1'b1, s, d, 1'b1, req);
  endtask

  // monitor: compares each queued item one step after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        expItem_t it;
        it = expQ.pop_front();
        check(pwmOut, it.val, it.req);
      end
    end
  end

  initial begin
    #20000000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check(pwmOut, 1'b0, "R1 in reset");
    @(negedge clk) rstN = 1'b1;
    @(posedge clk); #1 check(pwmOut, 1'b0, "R1 after reset");

    // R3: direct load while stopped, output at starting level
    wr(2'd0, 4'd4, "R3");
    wr(2'd1, 4'd1, "R3");
    run(3, 1'b1, "R3");
    // R9: check case, 75 percent high, period 4
    wr(2'd2, 4'b01, "R9");
    run(12, 1'b1, "R9");
    // R2: ticks on alternate cycles only
    for (int i = 0; i < 8; i++) begin
      step(1'b0, 2'd0, '0, 1'b1, "R2");
      step(1'b0, 2'd0, '0, 1'b0, "R2");
    end
    // R5: mid-period update is deferred to the wrap
    wr(2'd0, 4'd6, "R5");
    wr(2'd1, 4'd3, "R5");
    run(14, 1'b1, "R5");
    // R8: select 3 does nothing
    step(1'b1, 2'd3, 4'hF, 1'b1, "R8");
    run(6, 1'b1, "R8");
    // R3 and R4: stop, flip polarity, restart
    wr(2'd2, 4'b10, "R3");
    run(2, 1'b1, "R3");
    wr(2'd2, 4'b11, "R4");
    run(12, 1'b1, "R4");
    // R6: duty 0, then duty above period
    wr(2'd1, 4'd0, "R6");
    run(14, 1'b1, "R6");
    wr(2'd1, 4'd7, "R6");
    run(14, 1'b1, "R6");
    // R2: full-scale period with a match on the last count
    wr(2'd2, 4'b00, "R3");
    wr(2'd0, 4'd15, "R3");
    wr(2'd1, 4'd14, "R3");
    wr(2'd2, 4'b01, "R2");
    run(34, 1'b1, "R2");
    // R7: zero period while running
    wr(2'd0, 4'd0, "R7");
    run(20, 1'b1, "R7");
    wr(2'd2, 4'b00, "R7");
    wr(2'd0, 4'd0, "R7");
    wr(2'd2, 4'b11, "R7");
    run(6, 1'b1, "R7");

    @(negedge clk);
    wrEn = 1'b0; tick = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    driverDone = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule